// File: doc/BRIEF.md
# Saturating Add/Subtract Unit

A 32-bit signed arithmetic unit that performs one of four clamped operations per clock: plain add, plain subtract, and two forms that first double the second operand (clamping that doubled value) and then add it to or subtract it from the first operand. Every result that would fall outside the signed range is pinned to the largest or smallest representable value instead of wrapping.

Alongside the result the unit keeps a sticky saturation indicator. Any clamping, whether at the doubling step, the final step, or both, raises it, and no arithmetic operation ever lowers it. Only the dedicated clear input, standing in for a status-register write, lowers it. A qualifying enable input suppresses an operation entirely, which models conditional execution. Result and indicator are registered, so an operation presented at one rising edge is visible right after that edge.

Top module: `sat_arith_unit`

## Requirements
- R1: With opcode 2'b00 the result is A + B, clamped to 0x7FFFFFFF on positive overflow and to 0x80000000 on negative overflow.
- R2: With opcode 2'b01 the result is A − B with the same clamping; 0 − 0x80000000 gives 0x7FFFFFFF.
- R3: With opcode 2'b10 the result is A + D, clamped, where D is 2·B clamped to the signed range; doubling 0x40000000 gives D = 0x7FFFFFFF and doubling 0xC0000000 gives exactly 0x80000000 without clamping.
- R4: With opcode 2'b11 the result is A − D, clamped, with D defined as in R3.
- R5: When only the doubling step clamps, the result is the unclamped A ± D and the saturation indicator is still raised.
- R6: The saturation indicator rises after any enabled operation that clamps at any step and is never lowered by an operation, clamping or not.
- R7: A high clear input lowers the indicator at the next edge; if an enabled clamping operation occurs in the same cycle, the indicator ends high.
- R8: With enable low, the result holds its previous value and the indicator is not raised.
- R9: After reset the result is 0 and the indicator is low.
- R10: Result and indicator change only at the rising edge that samples the operation (one register stage).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Operation qualifier; low suppresses the operation |
| opSel | input | 2 | Operation code (00 add, 01 sub, 10 double-add, 11 double-sub) |
| opA | input | 32 | First signed operand |
| opB | input | 32 | Second signed operand (the one doubled) |
| clearFlag | input | 1 | Clears the saturation indicator |
| result | output | 32 | Registered clamped result |
| satFlag | output | 1 | Sticky saturation indicator |

## Verification
The only internal state is the result register and the sticky indicator, and both are outputs, so a wrong state is visible right after the edge that wrote it. A missed intermediate clamp shows as a wrong value or a low indicator one cycle after a doubling operation on an operand whose top two bits differ. A lost stickiness or wrong clear priority shows on the indicator in the cycle following the non-clamping or clearing operation, and the bench compares both outputs after every edge against a 64-bit reference model.

// File: rtl/sat_arith_pkg.sv
package sat_arith_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_DADD = 2'b10,
    OP_DSUB = 2'b11
  } satOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;    // load result, allow flag set
    logic clearReq;   // lower the sticky flag
    logic useDouble;  // route clamped 2*B instead of B
    logic subtract;   // A - operand instead of A + operand
  } dpStrobe_t;

endpackage

// File: rtl/sat_arith_ctrl.sv
module sat_arith_ctrl
  import sat_arith_pkg::*;
(
  input  logic       enable,
  input  logic [1:0] opSel,
  input  logic       clearFlag,
  output dpStrobe_t  strobe
);

  satOp_e opCode;

  always_comb begin
    opCode          = satOp_e'(opSel);
    strobe.capture  = enable;
    strobe.clearReq = clearFlag;
    unique case (opCode)
      OP_ADD:  begin strobe.useDouble = 1'b0; strobe.subtract = 1'b0; end
      OP_SUB:  begin strobe.useDouble = 1'b0; strobe.subtract = 1'b1; end
      OP_DADD: begin strobe.useDouble = 1'b1; strobe.subtract = 1'b0; end
      default: begin strobe.useDouble = 1'b1; strobe.subtract = 1'b1; end
    endcase
  end

endmodule

// File: rtl/sat_arith_dp.sv
module sat_arith_dp
  import sat_arith_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              satFlag
);

  localparam logic [DATA_W-1:0] MAX_VAL = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MIN_VAL = {1'b1, {(DATA_W-1){1'b0}}};

  logic              dblOvf;
  logic [DATA_W-1:0] dblVal;
  logic [DATA_W-1:0] secondOp;
  logic [DATA_W:0]   wideSum;
  logic              finalOvf;
  logic [DATA_W-1:0] nextResult;
  logic              satHit;

  // Doubling clamps when the two top bits of B disagree
  always_comb begin
    dblOvf = opB[DATA_W-1] ^ opB[DATA_W-2];
    if (dblOvf) dblVal = opB[DATA_W-1] ? MIN_VAL : MAX_VAL;
    else        dblVal = {opB[DATA_W-2:0], 1'b0};
    secondOp = strobe.useDouble ? dblVal : opB;
  end

  // One extra bit of headroom for the final step
  always_comb begin
    if (strobe.subtract)
      wideSum = {opA[DATA_W-1], opA} - {secondOp[DATA_W-1], secondOp};
    else
      wideSum = {opA[DATA_W-1], opA} + {secondOp[DATA_W-1], secondOp};
    finalOvf = wideSum[DATA_W] ^ wideSum[DATA_W-1];
    if (finalOvf) nextResult = wideSum[DATA_W] ? MIN_VAL : MAX_VAL;
    else          nextResult = wideSum[DATA_W-1:0];
    satHit = finalOvf | (strobe.useDouble & dblOvf);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result  <= '0;
      satFlag <= 1'b0;
    end else begin
      if (strobe.capture) result <= nextResult;
      if (strobe.capture && satHit) satFlag <= 1'b1;
      else if (strobe.clearReq)     satFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/sat_arith_unit.sv
module sat_arith_unit
  import sat_arith_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic [1:0]  opSel,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic        clearFlag,
  output logic [31:0] result,
  output logic        satFlag
);

  localparam int DATA_W = 32;

  dpStrobe_t strobe;

  sat_arith_ctrl u_ctrl (
    .enable    (enable),
    .opSel     (opSel),
    .clearFlag (clearFlag),
    .strobe    (strobe)
  );

  sat_arith_dp #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .opA     (opA),
    .opB     (opB),
    .result  (result),
    .satFlag (satFlag)
  );

endmodule

// File: rtl/sat_arith_checker.sv
module sat_arith_checker (
  input logic        clk,
  input logic        rstN,
  input logic        enable,
  input logic [1:0]  opSel,
  input logic [31:0] opA,
  input logic [31:0] opB,
  input logic        clearFlag,
  input logic [31:0] result,
  input logic        satFlag
);

  // Same-sign addition never flips sign under clamping
  p_add_sign_r1: assert property (@(posedge clk) disable iff (!rstN)
    enable && opSel == 2'b00 && opA[31] == opB[31] |=> result[31] == $past(opA[31]));

  // Opposite-sign subtraction keeps the sign of A
  p_sub_sign_r2: assert property (@(posedge clk) disable iff (!rstN)
    enable && opSel == 2'b01 && opA[31] != opB[31] |=> result[31] == $past(opA[31]));

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    satFlag && !clearFlag |=> satFlag);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    clearFlag && !enable |=> !satFlag);

  p_hold_result_r8: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> $stable(result));

  p_no_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !$rose(satFlag));

endmodule

bind sat_arith_unit sat_arith_checker u_chk (.*);

// File: tb/sat_arith_unit_bench.sv
`timescale 1ns/1ps
module sat_arith_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  opSel = 2'b00;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        clearFlag = 1'b0;
  logic [31:0] result;
  logic        satFlag;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [31:0] expResult = '0;
  logic        expFlag = 1'b0;

  always #5 clk = ~clk;

  sat_arith_unit u_sat_arith_unit (.*);

  localparam longint MAXL = 64'sd2147483647;
  localparam longint MINL = -64'sd2147483648;

  function automatic longint clampL(longint v, ref bit hit);
    if (v > MAXL) begin hit = 1; return MAXL; end
    if (v < MINL) begin hit = 1; return MINL; end
    return v;
  endfunction

  function automatic logic [31:0] refOp(logic [31:0] a, logic [31:0] b,
                                        logic [1:0] op, ref bit hit);
    longint la = longint'($signed(a));
    longint lb = longint'($signed(b));
    longint d, r;
    hit = 0;
    d = op[1] ? clampL(2 * lb, hit) : lb;
    r = op[0] ? la - d : la + d;
    r = clampL(r, hit);
    return r[31:0];
  endfunction

  function automatic string opTag(logic [1:0] op);
    case (op)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check1(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // Drive at negedge, sample 1 ns after the following rising edge
  task automatic step(logic [31:0] a, logic [31:0] b, logic [1:0] op,
                      logic en, logic clr, string tag, string flagTag);
    bit hit;
    logic [31:0] r;
    @(negedge clk);
    opA = a; opB = b; opSel = op; enable = en; clearFlag = clr;
    r = refOp(a, b, op, hit);
    if (en) expResult = r;
    expFlag = (en && hit) ? 1'b1 : (clr ? 1'b0 : expFlag);
    @(posedge clk); #1;
    check32(tag, result, expResult);
    check1(flagTag, satFlag, expFlag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check32("R9 reset result", result, 32'h0);
    check1("R9 reset flag", satFlag, 1'b0);
    @(negedge clk); rstN = 1'b1;

    // Directed corners
    step(32'h7FFF_FFFF, 32'h0000_0001, 2'b00, 1, 0, "R1 pos clamp", "R6 set");
    step(32'h0000_0005, 32'h0000_0003, 2'b00, 1, 0, "R1 plain", "R6 sticky");
    step(32'h0000_0000, 32'h0000_0000, 2'b00, 1, 1, "R1 zero", "R7 clear");
    step(32'h8000_0000, 32'hFFFF_FFFF, 2'b00, 1, 0, "R1 neg clamp", "R6 set");
    step(32'h0, 32'h0, 2'b00, 1, 1, "R1 zero", "R7 clear");
    step(32'h0000_0000, 32'h8000_0000, 2'b01, 1, 0, "R2 0-min", "R6 set");
    step(32'h0, 32'h0, 2'b00, 0, 1, "R8 hold", "R7 clear idle");
    // R5: doubling clamps to 0x7FFFFFFF, then -1 gives unclamped 0x7FFFFFFE
    step(32'hFFFF_FFFF, 32'h4000_0000, 2'b10, 1, 0, "R5 result", "R5 flag");
    step(32'h0, 32'h0, 2'b00, 1, 1, "R1 zero", "R7 clear");
    // R3: 0xC0000000 doubles exactly to 0x80000000
    step(32'h0000_0000, 32'hC000_0000, 2'b10, 1, 0, "R3 exact dbl", "R3 no flag");
    step(32'h0000_0001, 32'hC000_0000, 2'b11, 1, 0, "R4 dsub clamp", "R6 set");
    // R7: set wins over clear
    step(32'h7FFF_FFFF, 32'h7FFF_FFFF, 2'b00, 1, 1, "R1 pos clamp", "R7 set wins");
    step(32'h7FFF_FFFF, 32'h7FFF_FFFF, 2'b00, 1, 1, "R1 pos clamp", "R7 set wins again");
    step(32'h0, 32'h0, 2'b00, 1, 1, "R1 zero", "R7 clear");
    // R8: suppressed clamping op changes nothing
    step(32'h7FFF_FFFF, 32'h1, 2'b00, 0, 0, "R8 hold result", "R8 no set");

    // R10: new inputs not visible before the edge
    @(negedge clk);
    opA = 32'h0000_1234; opB = 32'h0000_0001; opSel = 2'b00; enable = 1'b1; clearFlag = 1'b0;
    #3;
    check32("R10 before edge", result, expResult);
    @(posedge clk); #1;
    expResult = 32'h0000_1235;
    check32("R10 after edge", result, expResult);

    // Random mix, biased toward extreme operands
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      logic [1:0] op;
      a = $urandom;
      b = $urandom;
      if ($urandom % 4 == 0) a = {a[31], {31{~a[31]}}};
      if ($urandom % 4 == 0) b = {b[31], ~b[31], b[29:0]};
      op = 2'($urandom);
      step(a, b, op, ($urandom % 8) != 0, ($urandom % 6) == 0, opTag(op), "R6 flag");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule